// File: doc/BRIEF.md
# Programmable ramp waveform generator

This block produces a stepped ramp of 12-bit codes for a converter. It keeps four ramp profiles side by side. Each profile word packs a start code, an end code, a step size, a direction bit and a repeat bit. Software arms a profile by setting its trigger bit. The block then loads the start code and moves the output by the step size once per update tick. When the ramp reaches the end code it either holds there or goes back to the start code and runs again. Reaching the end raises a sticky completion flag, which is cleared by writing one. The flag can drive an interrupt line and a DMA request line, each behind its own enable.

The update tick comes from a 16-bit interval count, so one tick happens every `tickDiv + 1` clock cycles. The trigger bits work in one of two ways. In single mode a bit clears itself when its ramp starts, and that ramp then runs on its own. In continuous mode a bit is a level: the ramp runs only while the level is held, and it freezes when the level is removed. If several profiles are armed at once, the lowest-numbered one starts first.

Top module: `ramp_gen`

## Requirements
- R1: After reset, `codeOut`, `trigState`, `doneSts`, `irqOut` and `dmaReq` are all zero.
- R2: Each 32-bit profile word holds the start code in bits 11:0, the step size in bits 15:12, the end code in bits 27:16, the direction in bit 28 (0 counts up, 1 counts down) and the repeat option in bit 29. Profile n sits at bits 32n+31:32n of `profileCfg`.
- R3: A write to the trigger bits takes effect at the clock edge where `swTrigWr` is sampled high. On the following edge, an idle block loads the start code of the armed profile onto `codeOut`.
- R4: While a ramp runs, `codeOut` changes only on update ticks. The first tick comes `tickDiv + 1` edges after the start code was loaded, and each later tick comes `tickDiv + 1` edges after the one before.
- R5: On each tick the code moves by the step size: up when the direction bit is 0, down when it is 1.
- R6: If a step would reach or pass the end code, `codeOut` becomes exactly the end code. That step counts as completion and sets `doneSts` at the same edge.
- R7: With the repeat bit at 0, the code stays at the end code after completion.
- R8: With the repeat bit at 1, the tick after completion reloads the start code and the ramp continues.
- R9: A step size of 0 keeps `codeOut` at the start code on every tick, and the ramp never completes.
- R10: When more than one trigger bit is set, the lowest-numbered profile starts first. The others stay pending and start, again lowest first, once the running ramp has finished.
- R11: With `contMode` at 0, the trigger bit of the started profile clears itself when its ramp starts. With `contMode` at 1, the bit stays set, and clearing it stops the ramp with `codeOut` frozen.
- R12: `doneSts` stays set until `doneClr` is pulsed; if a completion happens in the same cycle, the completion wins. `irqOut` follows `doneSts` gated by `irqEn`, and `dmaReq` follows `doneSts` gated by `dmaEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| profileCfg | input | 128 | Four packed profile words, profile 0 in the low bits |
| tickDiv | input | 16 | Update interval minus one, in clock cycles |
| contMode | input | 1 | 1 makes trigger bits levels, 0 makes them self-clearing |
| swTrigWr | input | 1 | Write strobe for the trigger bits |
| swTrigData | input | 4 | New value of the trigger bits |
| doneClr | input | 1 | Write-one-to-clear pulse for the completion flag |
| irqEn | input | 1 | Interrupt enable for completion |
| dmaEn | input | 1 | DMA request enable for completion |
| codeOut | output | 12 | Current converter code |
| trigState | output | 4 | Current trigger bits |
| doneSts | output | 1 | Sticky completion flag |
| irqOut | output | 1 | Completion interrupt |
| dmaReq | output | 1 | Completion DMA request |

## Verification
Two kinds of internal fault show up on `codeOut`. A wrong tick count moves the code one edge early or late, and that is visible at the first tick after the load. A wrong step, direction or clamp gives a wrong code at the first affected tick. The bench sweeps every step size in both directions over short spans, with several tick intervals. At every edge between ticks it compares `codeOut` with an arithmetic model, so any such error is caught within one update interval. A bad completion decision shows in `doneSts` at the very edge where the end code appears, or in a start reload that comes too early or too late. Bad trigger bookkeeping shows in `trigState` one edge after the ramp starts.

// File: rtl/ramp_pkg.sv
package ramp_pkg;
  localparam int NUM_PROF  = 4;
  localparam int PROF_W    = $clog2(NUM_PROF);
  localparam int CFG_W     = 32;
  localparam int CODE_W    = 12;
  localparam int STEP_W    = 4;
  localparam int TICK_W    = 16;
  // profile word layout
  localparam int START_LSB = 0;
  localparam int STEP_LSB  = START_LSB + CODE_W;
  localparam int END_LSB   = STEP_LSB + STEP_W;
  localparam int DIR_BIT   = END_LSB + CODE_W;
  localparam int REP_BIT   = DIR_BIT + 1;

  typedef struct packed {
    logic loadStart;
    logic doStep;
  } strobe_t;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_HOLD} state_t;
endpackage

// File: rtl/ramp_dp.sv
module ramp_dp
  import ramp_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_PROF*CFG_W-1:0]    profileCfg,
  input  logic [PROF_W-1:0]            profSel,
  input  strobe_t                      stb,
  output logic [CODE_W-1:0]            codeOut,
  output logic                         hitEnd,
  output logic                         zeroStep,
  output logic                         repeatEn,
  output logic [CODE_W-1:0]            curStart,
  output logic [CODE_W-1:0]            curEnd
);
  logic [CFG_W-1:0]  cfgWord;
  logic [STEP_W-1:0] stepSize;
  logic              goDown;
  logic [CODE_W:0]   sumUp;
  logic [CODE_W:0]   diffDown;
  logic [CODE_W-1:0] nextCode;
  logic              hitUp;
  logic              hitDown;

  always_comb begin
    cfgWord  = profileCfg[profSel*CFG_W +: CFG_W];
    curStart = cfgWord[START_LSB +: CODE_W];
    stepSize = cfgWord[STEP_LSB +: STEP_W];
    curEnd   = cfgWord[END_LSB +: CODE_W];
    goDown   = cfgWord[DIR_BIT];
    repeatEn = cfgWord[REP_BIT];
    zeroStep = (stepSize == '0);
    sumUp    = {1'b0, codeOut} + {{(CODE_W+1-STEP_W){1'b0}}, stepSize};
    diffDown = {1'b0, codeOut} - {{(CODE_W+1-STEP_W){1'b0}}, stepSize};
    hitUp    = (sumUp >= {1'b0, curEnd});
    hitDown  = diffDown[CODE_W] || (diffDown[CODE_W-1:0] <= curEnd);
    nextCode = goDown ? diffDown[CODE_W-1:0] : sumUp[CODE_W-1:0];
    hitEnd   = !zeroStep && (goDown ? hitDown : hitUp);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeOut <= '0;
    end else if (stb.loadStart) begin
      codeOut <= curStart;
    end else if (stb.doStep && !zeroStep) begin
      codeOut <= hitEnd ? curEnd : nextCode;
    end
  end
endmodule

// File: rtl/ramp_ctrl.sv
module ramp_ctrl
  import ramp_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 contMode,
  input  logic [TICK_W-1:0]    tickDiv,
  input  logic                 swTrigWr,
  input  logic [NUM_PROF-1:0]  swTrigData,
  input  logic                 doneClr,
  input  logic                 hitEnd,
  input  logic                 repeatEn,
  output strobe_t              stb,
  output logic [PROF_W-1:0]    profSel,
  output logic [NUM_PROF-1:0]  trigState,
  output logic                 doneSts
);
  state_t              state, stateN;
  logic [TICK_W-1:0]   tickCnt, tickCntN;
  logic [PROF_W-1:0]   curProf, curProfN;
  logic                wrapPend, wrapPendN;
  logic [NUM_PROF-1:0] trigClr;
  logic [PROF_W-1:0]   pickIdx;
  logic                pickValid;
  logic                loadStart;
  logic                doStep;
  logic                doneEvt;

  // lowest-numbered armed profile wins
  always_comb begin
    pickIdx   = '0;
    pickValid = |trigState;
    for (int i = NUM_PROF - 1; i >= 0; i--) begin
      if (trigState[i]) pickIdx = PROF_W'(i);
    end
  end

  assign profSel = (state == ST_IDLE) ? pickIdx : curProf;

  always_comb begin
    stateN    = state;
    tickCntN  = tickCnt;
    curProfN  = curProf;
    wrapPendN = wrapPend;
    trigClr   = '0;
    loadStart = 1'b0;
    doStep    = 1'b0;
    doneEvt   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (pickValid) begin
          loadStart = 1'b1;
          curProfN  = pickIdx;
          stateN    = ST_RUN;
          tickCntN  = '0;
          wrapPendN = 1'b0;
          if (!contMode) trigClr[pickIdx] = 1'b1;
        end
      end
      ST_RUN: begin
        if (contMode && !trigState[curProf]) begin
          stateN    = ST_IDLE;
          wrapPendN = 1'b0;
        end else if (tickCnt == tickDiv) begin
          tickCntN = '0;
          if (wrapPend) begin
            loadStart = 1'b1;
            wrapPendN = 1'b0;
          end else begin
            doStep = 1'b1;
            if (hitEnd) begin
              doneEvt = 1'b1;
              if (repeatEn) wrapPendN = 1'b1;
              else          stateN    = ST_HOLD;
            end
          end
        end else begin
          tickCntN = tickCnt + 1'b1;
        end
      end
      ST_HOLD: begin
        if (!(contMode && trigState[curProf])) stateN = ST_IDLE;
      end
      default: stateN = ST_IDLE;
    endcase
  end

  assign stb = '{loadStart: loadStart, doStep: doStep};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      tickCnt   <= '0;
      curProf   <= '0;
      wrapPend  <= 1'b0;
      trigState <= '0;
      doneSts   <= 1'b0;
    end else begin
      state     <= stateN;
      tickCnt   <= tickCntN;
      curProf   <= curProfN;
      wrapPend  <= wrapPendN;
      trigState <= swTrigWr ? swTrigData : (trigState & ~trigClr);
      doneSts   <= doneEvt | (doneSts & ~doneClr);
    end
  end
endmodule

// File: rtl/ramp_gen.sv
module ramp_gen
  import ramp_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_PROF*CFG_W-1:0]  profileCfg,
  input  logic [TICK_W-1:0]          tickDiv,
  input  logic                       contMode,
  input  logic                       swTrigWr,
  input  logic [NUM_PROF-1:0]        swTrigData,
  input  logic                       doneClr,
  input  logic                       irqEn,
  input  logic                       dmaEn,
  output logic [CODE_W-1:0]          codeOut,
  output logic [NUM_PROF-1:0]        trigState,
  output logic                       doneSts,
  output logic                       irqOut,
  output logic                       dmaReq
);
  strobe_t           stb;
  logic [PROF_W-1:0] profSel;
  logic              hitEnd;
  logic              zeroStep;
  logic              repeatEn;
  logic [CODE_W-1:0] curStart;
  logic [CODE_W-1:0] curEnd;

  ramp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .contMode(contMode), .tickDiv(tickDiv),
    .swTrigWr(swTrigWr), .swTrigData(swTrigData), .doneClr(doneClr),
    .hitEnd(hitEnd), .repeatEn(repeatEn), .stb(stb), .profSel(profSel),
    .trigState(trigState), .doneSts(doneSts)
  );

  ramp_dp u_dp (
    .clk(clk), .rstN(rstN), .profileCfg(profileCfg), .profSel(profSel),
    .stb(stb), .codeOut(codeOut), .hitEnd(hitEnd), .zeroStep(zeroStep),
    .repeatEn(repeatEn), .curStart(curStart), .curEnd(curEnd)
  );

  assign irqOut = doneSts & irqEn;
  assign dmaReq = doneSts & dmaEn;
endmodule

// File: rtl/ramp_gen_chk.sv
module ramp_gen_chk
  import ramp_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input strobe_t           stb,
  input logic              hitEnd,
  input logic              zeroStep,
  input logic [CODE_W-1:0] curStart,
  input logic [CODE_W-1:0] curEnd,
  input logic [CODE_W-1:0] codeOut,
  input logic              doneClr,
  input logic              doneSts
);
  // R3: a load strobe puts the selected start code on the output
  p_load_start_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadStart |=> codeOut == $past(curStart));

  // R4: without a strobe the output holds
  p_hold_between_ticks_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.loadStart && !stb.doStep) |=> $stable(codeOut));

  // R6: a step that reaches the end lands exactly on it and flags completion
  p_clamp_end_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.doStep && hitEnd) |=> (codeOut == $past(curEnd)) && doneSts);

  // R9: a zero step never moves the output
  p_zero_step_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stb.doStep && zeroStep) |=> $stable(codeOut));

  // R12: a clear without a coinciding completion drops the flag
  p_done_clear_r12: assert property (@(posedge clk) disable iff (!rstN)
    (doneClr && !(stb.doStep && hitEnd)) |=> !doneSts);
endmodule

bind ramp_gen ramp_gen_chk u_chk (
  .clk(clk), .rstN(rstN), .stb(stb), .hitEnd(hitEnd), .zeroStep(zeroStep),
  .curStart(curStart), .curEnd(curEnd), .codeOut(codeOut),
  .doneClr(doneClr), .doneSts(doneSts)
);

// File: tb/sim_ramp_gen.sv
`timescale 1ns/1ps
module sim_ramp_gen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] cfgW [4];
  logic [127:0] profileCfg;
  logic [15:0] tickDiv = '0;
  logic        contMode = 1'b0;
  logic        swTrigWr = 1'b0;
  logic [3:0]  swTrigData = '0;
  logic        doneClr = 1'b0;
  logic        irqEn = 1'b0;
  logic        dmaEn = 1'b0;
  logic [11:0] codeOut;
  logic [3:0]  trigState;
  logic        doneSts, irqOut, dmaReq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  assign profileCfg = {cfgW[3], cfgW[2], cfgW[1], cfgW[0]};

  ramp_gen u0 (
    .clk(clk), .rstN(rstN), .profileCfg(profileCfg), .tickDiv(tickDiv),
    .contMode(contMode), .swTrigWr(swTrigWr), .swTrigData(swTrigData),
    .doneClr(doneClr), .irqEn(irqEn), .dmaEn(dmaEn), .codeOut(codeOut),
    .trigState(trigState), .doneSts(doneSts), .irqOut(irqOut), .dmaReq(dmaReq)
  );

  always #10 clk = ~clk;  // 50 MHz

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // R2: profile word layout
  function automatic logic [31:0] mk(input int st, input int en, input int sp,
                                     input int dn, input int rp);
    return {2'b00, rp[0], dn[0], en[11:0], sp[3:0], st[11:0]};
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; swTrigWr = 1'b0; doneClr = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic arm(input logic [3:0] bits);
    @(negedge clk);
    swTrigWr = 1'b1; swTrigData = bits;
    @(negedge clk);   // trigger register set at this edge
    swTrigWr = 1'b0;
  endtask

  // wait one update interval, checking the hold cycles, return at the tick
  task automatic waitTick(input int d, input int hold, input string tag);
    for (int k = 0; k < d; k++) begin
      @(negedge clk);
      chk(codeOut == hold[11:0], tag, codeOut, hold);
    end
    @(negedge clk);
  endtask

  task automatic runRamp(input int p, input int st, input int en, input int sp,
                         input int dn, input int rp, input int d);
    int v, n, guard;
    bit fin;
    doReset();
    cfgW[p] = mk(st, en, sp, dn, rp);
    tickDiv = d[15:0];
    contMode = 1'b0;
    arm(4'(1 << p));
    @(negedge clk);
    chk(codeOut == st[11:0], "R3 start load", codeOut, st);
    chk(trigState == 4'b0, "R11 single self-clear", trigState, 0);
    v = st; fin = 0; guard = 0;
    if (sp == 0) begin
      for (int t = 0; t < 3; t++) begin
        waitTick(d, v, "R4 hold between ticks");
        chk(codeOut == st[11:0], "R9 zero step hold", codeOut, st);
        chk(doneSts == 1'b0, "R9 zero step no completion", doneSts, 0);
      end
      return;
    end
    while (!fin && guard < 80) begin
      waitTick(d, v, "R4 hold between ticks");
      n = dn ? v - sp : v + sp;
      if (dn ? (n <= en) : (n >= en)) begin
        n = en; fin = 1;
      end
      v = n;
      chk(codeOut == v[11:0], fin ? "R6 clamp to end" : "R5 step value", codeOut, v);
      chk(doneSts == fin, "R6 completion flag", doneSts, fin);
      guard++;
    end
    waitTick(d, v, "R4 hold after end");
    if (rp != 0) begin
      chk(codeOut == st[11:0], "R8 repeat reload", codeOut, st);
      waitTick(d, st, "R8 hold after reload");
      n = dn ? st - sp : st + sp;
      if (dn ? (n <= en) : (n >= en)) n = en;
      chk(codeOut == n[11:0], "R8 step after reload", codeOut, n);
    end else begin
      chk(codeOut == en[11:0], "R7 stop at end", codeOut, en);
      waitTick(d, en, "R7 hold at end");
      chk(codeOut == en[11:0], "R7 still at end", codeOut, en);
    end
  endtask

  initial begin
    for (int i = 0; i < 4; i++) cfgW[i] = '0;
    doReset();
    @(negedge clk);
    chk(codeOut == 0, "R1 reset code", codeOut, 0);
    chk(trigState == 0, "R1 reset triggers", trigState, 0);
    chk(doneSts == 0, "R1 reset done", doneSts, 0);
    chk(irqOut == 0 && dmaReq == 0, "R1 reset irq/dma", {irqOut, dmaReq}, 0);

    // sweep every step size in both directions over several intervals
    for (int dn = 0; dn < 2; dn++)
      for (int sp = 0; sp < 16; sp++) begin
        if (dn == 0) runRamp(sp % 4, 5, 40, sp, 0, 0, sp % 3);
        else         runRamp(sp % 4, 40, 5, sp, 1, 0, sp % 3);
      end
    // repeat option, both directions; boundary ends
    runRamp(2, 0, 9, 3, 0, 1, 1);
    runRamp(3, 4095, 4090, 2, 1, 1, 0);
    runRamp(1, 4090, 4095, 15, 0, 0, 2);
    runRamp(0, 3, 0, 7, 1, 0, 0);

    // R12: flag gating and write-one-to-clear (done is set from last ramp)
    @(negedge clk);
    irqEn = 1'b1; dmaEn = 1'b0;
    #1;
    chk(irqOut == 1'b1, "R12 irq follows done", irqOut, 1);
    chk(dmaReq == 1'b0, "R12 dma gated off", dmaReq, 0);
    dmaEn = 1'b1;
    #1;
    chk(dmaReq == 1'b1, "R12 dma follows done", dmaReq, 1);
    @(negedge clk);
    chk(doneSts == 1'b1, "R12 done sticky", doneSts, 1);
    doneClr = 1'b1;
    @(negedge clk);
    doneClr = 1'b0;
    chk(doneSts == 1'b0, "R12 done cleared", doneSts, 0);
    chk(irqOut == 1'b0 && dmaReq == 1'b0, "R12 lines drop", {irqOut, dmaReq}, 0);
    irqEn = 1'b0; dmaEn = 1'b0;

    // R10: priority between two armed profiles
    doReset();
    cfgW[1] = mk(100, 106, 3, 0, 0);
    cfgW[2] = mk(200, 230, 5, 0, 0);
    tickDiv = 16'd0;
    arm(4'b0110);
    @(negedge clk);
    chk(codeOut == 100, "R10 lowest profile first", codeOut, 100);
    chk(trigState == 4'b0100, "R10 other stays pending", trigState, 4);
    @(negedge clk);
    chk(codeOut == 103, "R10 first profile steps", codeOut, 103);
    @(negedge clk);
    chk(codeOut == 106 && doneSts, "R10 first profile ends", codeOut, 106);
    @(negedge clk);
    @(negedge clk);
    chk(codeOut == 200, "R10 pending profile starts", codeOut, 200);
    chk(trigState == 4'b0000, "R10 pending cleared", trigState, 0);

    // R11: continuous mode level trigger and stop
    doReset();
    cfgW[0] = mk(10, 50, 4, 0, 0);
    tickDiv = 16'd3;
    contMode = 1'b1;
    arm(4'b0001);
    @(negedge clk);
    chk(codeOut == 10, "R11 continuous start", codeOut, 10);
    chk(trigState == 4'b0001, "R11 level kept", trigState, 1);
    waitTick(3, 10, "R4 continuous hold");
    chk(codeOut == 14, "R11 continuous step", codeOut, 14);
    swTrigWr = 1'b1; swTrigData = 4'b0000;
    @(negedge clk);
    swTrigWr = 1'b0;
    for (int k = 0; k < 10; k++) @(negedge clk);
    chk(codeOut == 14, "R11 frozen after level removed", codeOut, 14);
    chk(trigState == 4'b0000, "R11 level cleared", trigState, 0);
    chk(doneSts == 1'b0, "R11 no completion on stop", doneSts, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule